// File: doc/BRIEF.md
# Left-Shift Sequential Unsigned Multiplier

This block multiplies two unsigned operands over several clock cycles using the shift-and-add method, with the accumulator held at a fixed position. A single-cycle `load` pulse captures both operands at once into their own registers and clears the running sum. On each following clock the block looks at one bit of the first operand, starting from the least significant. When that bit is one, it adds the second operand, already shifted left by that bit's position, into a double-width accumulator.

After one step per bit of the first operand, the accumulator holds the full product. A `done` flag then rises and the result stays on the output until the next load. The `product` output comes straight from the accumulator register. While the iteration runs, it shows the partial sum built so far. With the default operand width of 6, a result is ready six cycles after the load edge.

Top module: `seq_mult_lshift`

## Requirements
- R1: While `rst` is high at a rising clock edge (synchronous, active high), the next cycle shows `product` = 0 and `done` = 0, whatever `load` does in that cycle.
- R2: After a rising edge with `load` = 1 and `rst` = 0, `product` reads 0 and `done` reads 0 in the following cycle.
- R3: Exactly 6 rising edges after the load edge, `product` equals `opA` × `opB` as captured at the load edge, and `done` becomes 1. `done` stays 0 after steps 1 to 5.
- R4: Once `done` is 1 and no load arrives, `product` and `done` keep their values. Later changes on `opA` and `opB` have no effect on them.
- R5: A load during an iteration abandons the old operands and restarts with the new ones. The result follows 6 edges after the later load, and the abandoned product never appears with `done` = 1.
- R6: After step k (k = 1..6), `product` equals (`opA` mod 2^k) × `opB`, because bit k-1 of `opA` adds `opB`·2^(k-1).
- R7: A reset during an iteration aborts it: `product` goes to 0, `done` stays 0, and no result appears afterwards without a new load.
- R8: `rst` has priority over `load` when both are high at the same edge. No iteration starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures both operands and starts a multiplication |
| opA | input | 6 | Multiplier; its bits are scanned LSB first |
| opB | input | 6 | Multiplicand |
| product | output | 12 | Registered accumulator, final product once done is 1 |
| done | output | 1 | High from completion until the next load or reset |

## Verification
All 4096 operand pairs are multiplied, so every carry chain the adder can see is covered. This includes 63 × 63 with its maximal carries, and the zero and unit operands that expose a stuck add enable.

A subset of the runs also checks every partial sum step by step. This separates a wrong shift direction or wrong bit order from a wrong final add. Alternating patterns such as 42 and 21 make a one-position slip visible.

Further runs check three more cases. A restart load mid-iteration, a mid-iteration reset, and a reset coinciding with load test the control priority. Operand toggling after completion confirms that the held result ignores the inputs.

// File: rtl/mult_pkg.sv
package mult_pkg;

  // Strobes issued by the sequencer to the datapath each cycle
  typedef struct packed {
    logic loadOps;  // capture operands, clear accumulator
    logic step;     // perform one shift-and-add iteration
  } multStrobe_t;

endpackage

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
#(
  parameter int OPW = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  output multStrobe_t strobes,
  output logic        done
);

  localparam int CW = $clog2(OPW + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(OPW - 1);

  logic [CW-1:0] stepCount;
  logic          busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      stepCount <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else if (load) begin
      stepCount <= '0;
      busy      <= 1'b1;
      done      <= 1'b0;
    end else if (busy) begin
      if (stepCount == LAST_STEP) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      stepCount <= stepCount + 1'b1;
    end
  end

  always_comb begin
    strobes.loadOps = load;
    strobes.step    = busy && !load;
  end

endmodule

// File: rtl/mult_dpath.sv
module mult_dpath
  import mult_pkg::*;
#(
  parameter int OPW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  multStrobe_t     strobes,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  output logic [2*OPW-1:0] accOut
);

  localparam int PW = 2 * OPW;

  logic [PW-1:0]  mcandReg;  // multiplicand, weighted by 2^i
  logic [OPW-1:0] mplrReg;   // multiplier, LSB is current bit
  logic [PW-1:0]  accReg;
  logic [PW-1:0]  addend;

  always_comb begin
    addend = mplrReg[0] ? mcandReg : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcandReg <= '0;
      mplrReg  <= '0;
      accReg   <= '0;
    end else if (strobes.loadOps) begin
      mcandReg <= {{OPW{1'b0}}, opB};
      mplrReg  <= opA;
      accReg   <= '0;
    end else if (strobes.step) begin
      accReg   <= accReg + addend;
      mcandReg <= mcandReg << 1;
      mplrReg  <= mplrReg >> 1;
    end
  end

  assign accOut = accReg;

endmodule

// File: rtl/seq_mult_lshift.sv
module seq_mult_lshift
  import mult_pkg::*;
#(
  parameter int OPW = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OPW-1:0]   opA,
  input  logic [OPW-1:0]   opB,
  output logic [2*OPW-1:0] product,
  output logic             done
);

  multStrobe_t strobes;

  mult_ctrl #(.OPW(OPW)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .strobes (strobes),
    .done    (done)
  );

  mult_dpath #(.OPW(OPW)) uDpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .accOut  (product)
  );

endmodule

// File: rtl/mult_chk.sv
module mult_chk #(
  parameter int OPW = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic [OPW-1:0]   opA,
  input logic [OPW-1:0]   opB,
  input logic [2*OPW-1:0] product,
  input logic             done
);

  localparam int PW = 2 * OPW;
  localparam int KW = $clog2(OPW + 1) + 1;
  localparam logic [KW-1:0] KMAX = '1;

  logic [PW-1:0] expProd;
  logic [KW-1:0] sinceLoad;

  always_ff @(posedge clk) begin
    if (rst) begin
      expProd   <= '0;
      sinceLoad <= KMAX;
    end else if (load) begin
      expProd   <= PW'(opA) * PW'(opB);
      sinceLoad <= '0;
    end else if (sinceLoad != KMAX) begin
      sinceLoad <= sinceLoad + 1'b1;
    end
  end

  // R1 / R8: reset clears outputs even when load is high
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (product == '0 && !done));

  // R2: load clears the accumulator and the done flag
  assert_load_clears_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (product == '0 && !done));

  // R3: done rises exactly OPW edges after the load edge
  assert_done_timing_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (sinceLoad == KW'(OPW)));

  // R3 / R5: whenever done is high the product matches the latest load
  assert_result_value_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == expProd));

  // R4: completed result is held until the next load
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> (done && $stable(product)));

endmodule

bind seq_mult_lshift mult_chk #(.OPW(OPW)) uChk (
  .clk     (clk),
  .rst     (rst),
  .load    (load),
  .opA     (opA),
  .opB     (opB),
  .product (product),
  .done    (done)
);

// File: tb/tb_seq_mult_lshift.sv
`timescale 1ns/1ps
module tb_seq_mult_lshift;

  localparam int OPW = 6;
  localparam int PW  = 2 * OPW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           load = 1'b0;
  logic [OPW-1:0] opA = '0;
  logic [OPW-1:0] opB = '0;
  logic [PW-1:0]  product;
  logic           done;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [PW-1:0] expQ[$];
  logic          prevDone = 1'b0;

  always #2 clk = ~clk;

  seq_mult_lshift #(.OPW(OPW)) dut (
    .clk(clk), .rst(rst), .load(load),
    .opA(opA), .opB(opB), .product(product), .done(done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares each completed result against the scoreboard
  always @(negedge clk) begin
    if (done && !prevDone) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5/R7 unexpected result", product, '0);
      end else begin
        logic [PW-1:0] e;
        e = expQ.pop_front();
        check(product == e, "R3 final product", product, e);
      end
    end
    prevDone <= done;
  end

  // Driver: starts one multiplication, optionally checks every partial sum
  task automatic runMul(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                        input bit stepCheck);
    @(negedge clk);
    opA = a; opB = b; load = 1'b1;
    expQ.push_back(PW'(a) * PW'(b));
    @(negedge clk);
    load = 1'b0;
    if (stepCheck)
      check(product == '0 && !done, "R2 cleared after load", product, '0);
    for (int k = 1; k <= OPW; k++) begin
      @(negedge clk);
      if (stepCheck) begin
        logic [PW-1:0] part;
        part = PW'(a & ((OPW'(1) << k) - OPW'(1))) * PW'(b);
        if (k == OPW) part = PW'(a) * PW'(b);
        check(product == part, "R6 partial sum", product, part);
        check(done == (k == OPW), "R3 done timing", PW'(done), PW'(k == OPW));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(product == '0 && !done, "R1 reset state", product, '0);
    rst = 1'b0;

    // Step-checked patterns
    runMul(6'd42, 6'd21, 1'b1);
    runMul(6'd21, 6'd42, 1'b1);
    runMul(6'd63, 6'd63, 1'b1);
    runMul(6'd0,  6'd55, 1'b1);
    runMul(6'd55, 6'd0,  1'b1);
    runMul(6'd1,  6'd63, 1'b1);
    runMul(6'd32, 6'd63, 1'b1);

    // R4: hold with toggling operands
    begin
      logic [PW-1:0] held;
      held = product;
      opA = 6'd17; opB = 6'd9;
      repeat (5) @(negedge clk);
      opA = 6'd60;
      @(negedge clk);
      check(product == held && done, "R4 held result", product, held);
    end

    // R5: restart mid-iteration
    @(negedge clk);
    opA = 6'd3; opB = 6'd5; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    repeat (3) @(negedge clk);
    check(!done, "R5 not done mid-run", PW'(done), '0);
    runMul(6'd60, 6'd50, 1'b1);

    // R7: reset mid-iteration
    @(negedge clk);
    opA = 6'd33; opB = 6'd44; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(product == '0 && !done, "R7 aborted", product, '0);
    repeat (8) @(negedge clk);
    check(product == '0 && !done, "R7 stays idle", product, '0);

    // R8: reset and load together
    opA = 6'd7; opB = 6'd9; rst = 1'b1; load = 1'b1;
    @(negedge clk);
    rst = 1'b0; load = 1'b0;
    check(product == '0 && !done, "R8 reset wins", product, '0);
    repeat (8) @(negedge clk);
    check(product == '0 && !done, "R8 no start", product, '0);

    // Exhaustive sweep of operand pairs
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        runMul(OPW'(i), OPW'(j), 1'b0);

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R3 all results seen", PW'(expQ.size()), '0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule